// File: doc/BRIEF.md
# Dual-Bus Modulo Address Generator

This block produces the next value of two data-memory pointers, one on the X bus and one on the Y bus, for parallel data-move operations. Each bus owns a pair of 32-bit address registers and one 32-bit index register. In every cycle the X side and the Y side each pick one of their own address registers and an update mode. The selected register's current value goes out as that bus's address, and the register then takes its post-update value. The modes are hold, step by two, or add the bus's index register.

A shared range configuration holds a 16-bit wrap-to value and a 16-bit wrap-at value, plus one wrap enable per bus. A bus wraps when three things are true: its enable is set, its mode really updates the pointer, and bits 15:1 of the pointer before the update equal bits 15:1 of the wrap-at value. On a wrap, the pointer's low half is reloaded from the wrap-to value instead of advancing. This gives circular buffers of up to 64 KB with no software bounds check.

A write port loads the six registers. A second port loads the range configuration. Instruction decoding and the memory access itself belong to neighbouring logic.

Top module: `modaddr_gen`

## Requirements
- R1: A cfg_we pulse stores cfg_range[31:16] as the wrap-at value, cfg_range[15:0] as the wrap-to value, and cfg_wrap_x / cfg_wrap_y as the two enables. The new configuration governs data moves from the next cycle on. A move issued in the same cycle as the write still uses the previous configuration.
- R2: The mode codes are 2'b00 hold, 2'b01 add two, 2'b10 add index, and 2'b11 hold. x_addr and y_addr show the pre-update value of the selected register: x_sel 0/1 picks X registers 0/1, and y_sel 0/1 picks Y registers 0/1.
- R3: Without a wrap, an updating mode writes back the full 32-bit sum, and carries propagate into bits 31:16.
- R4: On a wrap, bits 15:1 of the pointer become bits 15:1 of the wrap-to value, bit 0 becomes zero, and bits 31:16 keep their previous value.
- R5: The wrap comparison ignores bit 0 of both the pointer and the wrap-at value.
- R6: A hold mode (00 or 11) leaves the pointer unchanged, even when it equals the wrap-at value.
- R7: Each bus wraps only when its own enable is set. With the enable clear, the bus updates linearly at the wrap-at value.
- R8: X and Y updates happen in the same cycle and do not affect each other. The X side uses only the X index register and the Y side uses only the Y index register.
- R9: reg_sel codes 0..1 write X registers 0..1, 2..3 write Y registers 0..1, 4 writes the X index and 5 writes the Y index. Codes 6 and 7 write nothing. A register write beats a same-cycle update of that register. An index written in the same cycle as an add-index move takes effect from the next move.
- R10: Reset clears all six registers, both values and both enables. After reset, a step of two from zero gives 2 with no wrap.
- R11: The add-index mode wraps under the same condition as the add-two mode, whatever the index value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load range configuration |
| cfg_range | input | 32 | Wrap-at value in [31:16], wrap-to value in [15:0] |
| cfg_wrap_x | input | 1 | Wrap enable written for the X bus |
| cfg_wrap_y | input | 1 | Wrap enable written for the Y bus |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register write target (see R9) |
| reg_wdata | input | 32 | Register write data |
| x_sel | input | 1 | X address register select |
| x_mode | input | 2 | X update mode |
| y_sel | input | 1 | Y address register select |
| y_mode | input | 2 | Y update mode |
| x_addr | output | 32 | Pre-update X address |
| y_addr | output | 32 | Pre-update Y address |

## Verification
Two pairs of functions can fall in one cycle. The first pair is a wrap on X and a wrap on Y. The bench provokes it by placing both pointers on the wrap-at value with both enables set, and issuing add-two on X and add-index on Y together. It then reads both registers back and expects each one on the wrap-to value with its own upper half kept. The second pair is a register write and a pointer update aimed at the same register. The bench issues both together and judges the result by reading back the written value. In that same cycle a move on the other bus must still complete, and the bench checks that it did.

// File: rtl/modaddr_pkg.sv
package modaddr_pkg;

    typedef enum logic [1:0] {
        UPD_HOLD  = 2'b00,
        UPD_INC2  = 2'b01,
        UPD_INDEX = 2'b10,
        UPD_RSVD  = 2'b11
    } upd_e;

    localparam int BUS_X = 0;
    localparam int BUS_Y = 1;
    localparam int NUM_BUS = 2;

    function automatic logic mode_updates(input logic [1:0] m);
        return (m == UPD_INC2) || (m == UPD_INDEX);
    endfunction

endpackage

// File: rtl/modaddr_cmp.sv
module modaddr_cmp #(
    parameter int MOD_W = 16
) (
    input  logic [MOD_W-1:1] ptr_hi,
    input  logic [MOD_W-1:1] end_hi,
    output logic             hit
);
    always_comb begin
        hit = (ptr_hi == end_hi);
    end
endmodule

// File: rtl/modaddr_lane.sv
module modaddr_lane
    import modaddr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MOD_W  = 16
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] idx,
    input  logic [1:0]        mode,
    input  logic              wrap_en,
    input  logic [MOD_W-1:1]  start_hi,
    input  logic [MOD_W-1:1]  end_hi,
    output logic [ADDR_W-1:0] nxt,
    output logic              wrapped
);
    logic              hit;
    logic              updating;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] sum;

    modaddr_cmp #(.MOD_W(MOD_W)) u_cmp (
        .ptr_hi (cur[MOD_W-1:1]),
        .end_hi (end_hi),
        .hit    (hit)
    );

    always_comb begin
        updating = mode_updates(mode);
        case (mode)
            UPD_INC2:  step = ADDR_W'(2);
            UPD_INDEX: step = idx;
            default:   step = '0;
        endcase
        sum     = cur + step;
        wrapped = wrap_en && updating && hit;
        if (wrapped) begin
            nxt = {cur[ADDR_W-1:MOD_W], start_hi, 1'b0};
        end else begin
            nxt = sum;
        end
    end
endmodule

// File: rtl/modaddr_gen.sv
module modaddr_gen
    import modaddr_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int MOD_W        = 16,
    parameter int PTRS_PER_BUS = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cfg_we,
    input  logic [2*MOD_W-1:0]                    cfg_range,
    input  logic                                  cfg_wrap_x,
    input  logic                                  cfg_wrap_y,
    input  logic                                  reg_we,
    input  logic [$clog2(2*PTRS_PER_BUS+2)-1:0]   reg_sel,
    input  logic [ADDR_W-1:0]                     reg_wdata,
    input  logic [$clog2(PTRS_PER_BUS)-1:0]       x_sel,
    input  logic [1:0]                            x_mode,
    input  logic [$clog2(PTRS_PER_BUS)-1:0]       y_sel,
    input  logic [1:0]                            y_mode,
    output logic [ADDR_W-1:0]                     x_addr,
    output logic [ADDR_W-1:0]                     y_addr
);
    localparam int NUM_AR = NUM_BUS * PTRS_PER_BUS;
    localparam int SEL_W  = $clog2(PTRS_PER_BUS);
    localparam int RSEL_W = $clog2(NUM_AR + NUM_BUS);

    typedef struct packed {
        logic [NUM_AR-1:0][ADDR_W-1:0]  ar;
        logic [NUM_BUS-1:0][ADDR_W-1:0] ix;
        logic [MOD_W-1:0]               ms;
        logic [MOD_W-1:0]               me;
        logic [NUM_BUS-1:0]             wen;
    } state_t;

    state_t st_d, st_q;

    logic [SEL_W-1:0]  bus_sel  [NUM_BUS];
    logic [1:0]        bus_mode [NUM_BUS];
    logic [ADDR_W-1:0] lane_cur [NUM_BUS];
    logic [ADDR_W-1:0] lane_nxt [NUM_BUS];
    logic [NUM_BUS-1:0] lane_wrap;

    always_comb begin
        bus_sel[BUS_X]  = x_sel;
        bus_sel[BUS_Y]  = y_sel;
        bus_mode[BUS_X] = x_mode;
        bus_mode[BUS_Y] = y_mode;
        for (int b = 0; b < NUM_BUS; b++) begin
            lane_cur[b] = '0;
            for (int p = 0; p < PTRS_PER_BUS; p++) begin
                if (bus_sel[b] == SEL_W'(p)) begin
                    lane_cur[b] = st_q.ar[b*PTRS_PER_BUS + p];
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_BUS; g++) begin : g_lane
            modaddr_lane #(.ADDR_W(ADDR_W), .MOD_W(MOD_W)) u_lane (
                .cur      (lane_cur[g]),
                .idx      (st_q.ix[g]),
                .mode     (bus_mode[g]),
                .wrap_en  (st_q.wen[g]),
                .start_hi (st_q.ms[MOD_W-1:1]),
                .end_hi   (st_q.me[MOD_W-1:1]),
                .nxt      (lane_nxt[g]),
                .wrapped  (lane_wrap[g])
            );
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        // pointer updates from both buses
        for (int b = 0; b < NUM_BUS; b++) begin
            for (int p = 0; p < PTRS_PER_BUS; p++) begin
                if (bus_sel[b] == SEL_W'(p)) begin
                    st_d.ar[b*PTRS_PER_BUS + p] = lane_nxt[b];
                end
            end
        end
        // register write port overrides a same-cycle update
        if (reg_we) begin
            for (int r = 0; r < NUM_AR; r++) begin
                if (reg_sel == RSEL_W'(r)) begin
                    st_d.ar[r] = reg_wdata;
                end
            end
            for (int b = 0; b < NUM_BUS; b++) begin
                if (reg_sel == RSEL_W'(NUM_AR + b)) begin
                    st_d.ix[b] = reg_wdata;
                end
            end
        end
        if (cfg_we) begin
            st_d.me         = cfg_range[2*MOD_W-1:MOD_W];
            st_d.ms         = cfg_range[MOD_W-1:0];
            st_d.wen[BUS_X] = cfg_wrap_x;
            st_d.wen[BUS_Y] = cfg_wrap_y;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign x_addr = lane_cur[BUS_X];
    assign y_addr = lane_cur[BUS_Y];

endmodule

// File: rtl/modaddr_chk.sv
module modaddr_chk
    import modaddr_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int MOD_W        = 16,
    parameter int PTRS_PER_BUS = 2
) (
    input logic                                          clk,
    input logic                                          rst_n,
    input logic                                          cfg_we,
    input logic [2*MOD_W-1:0]                            cfg_range,
    input logic                                          cfg_wrap_x,
    input logic                                          cfg_wrap_y,
    input logic                                          reg_we,
    input logic [$clog2(PTRS_PER_BUS)-1:0]               x_sel,
    input logic [1:0]                                    x_mode,
    input logic [1:0]                                    y_mode,
    input logic [2*PTRS_PER_BUS-1:0][ADDR_W-1:0]         ar,
    input logic [1:0][ADDR_W-1:0]                        ix,
    input logic [MOD_W-1:0]                              ms,
    input logic [MOD_W-1:0]                              me,
    input logic [1:0]                                    wen,
    input logic                                          wrap_x,
    input logic                                          wrap_y
);
    logic [$clog2(PTRS_PER_BUS)-1:0] xsel_q;

    always_ff @(posedge clk) begin
        xsel_q <= x_sel;
    end

    // R1: configuration captured from the write port
    assert_cfg_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (me == $past(cfg_range[2*MOD_W-1:MOD_W])) &&
                   (ms == $past(cfg_range[MOD_W-1:0])) &&
                   (wen == $past({cfg_wrap_y, cfg_wrap_x})));

    // R1: configuration kept without a write
    assert_cfg_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(ms) && $stable(me) && $stable(wen));

    // R7: no wrap on a bus whose enable is clear
    assert_wrap_gate_x_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wen[0] |-> !wrap_x);
    assert_wrap_gate_y_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wen[1] |-> !wrap_y);

    // R6: hold modes on both buses and no write leave all pointers as they were
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && !mode_updates(x_mode) && !mode_updates(y_mode)) |=> $stable(ar));

    // R8: Y registers untouched by anything the X bus does
    assert_y_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && !mode_updates(y_mode)) |=>
            $stable(ar[2*PTRS_PER_BUS-1:PTRS_PER_BUS]));

    // R4: wrap reloads low half from the wrap-to value with bit 0 cleared
    assert_wrap_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_x && !reg_we) |=> (ar[xsel_q][MOD_W-1:0] == {$past(ms[MOD_W-1:1]), 1'b0}));

    // R9: index registers change only through the write port
    assert_index_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(ix));

endmodule

bind modaddr_gen modaddr_chk #(
    .ADDR_W(ADDR_W), .MOD_W(MOD_W), .PTRS_PER_BUS(PTRS_PER_BUS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_range  (cfg_range),
    .cfg_wrap_x (cfg_wrap_x),
    .cfg_wrap_y (cfg_wrap_y),
    .reg_we     (reg_we),
    .x_sel      (x_sel),
    .x_mode     (x_mode),
    .y_mode     (y_mode),
    .ar         (st_q.ar),
    .ix         (st_q.ix),
    .ms         (st_q.ms),
    .me         (st_q.me),
    .wen        (st_q.wen),
    .wrap_x     (lane_wrap[0]),
    .wrap_y     (lane_wrap[1])
);

// File: tb/tb_modaddr_gen.sv
module tb_modaddr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_range = '0;
    logic        cfg_wrap_x = 1'b0;
    logic        cfg_wrap_y = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        x_sel = 1'b0;
    logic [1:0]  x_mode = 2'b00;
    logic        y_sel = 1'b0;
    logic [1:0]  y_mode = 2'b00;
    logic [31:0] x_addr, y_addr;

    always #4 clk = ~clk;

    modaddr_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_range(cfg_range),
        .cfg_wrap_x(cfg_wrap_x), .cfg_wrap_y(cfg_wrap_y),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .x_sel(x_sel), .x_mode(x_mode), .y_sel(y_sel), .y_mode(y_mode),
        .x_addr(x_addr), .y_addr(y_addr)
    );

    typedef struct {
        bit          cx;
        logic [31:0] xv;
        bit          cy;
        logic [31:0] yv;
        string       tag;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // monitor: one scoreboard item per driven cycle, compared mid-cycle
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            if (it.cx) begin
                n_chk++;
                if (x_addr !== it.xv) begin
                    n_fail++;
                    $display("FAIL %s x_addr actual=%h expected=%h", it.tag, x_addr, it.xv);
                end
            end
            if (it.cy) begin
                n_chk++;
                if (y_addr !== it.yv) begin
                    n_fail++;
                    $display("FAIL %s y_addr actual=%h expected=%h", it.tag, y_addr, it.yv);
                end
            end
        end
    end

    task automatic step(input bit xs, input logic [1:0] xm, input bit ys, input logic [1:0] ym,
                        input bit we, input logic [2:0] ws, input logic [31:0] wd,
                        input bit cwe, input logic [31:0] cr, input bit cx_en, input bit cy_en,
                        input bit chkx, input logic [31:0] xe, input bit chky, input logic [31:0] ye,
                        input string tag);
        item_t it;
        @(posedge clk);
        #1;
        x_sel = xs; x_mode = xm; y_sel = ys; y_mode = ym;
        reg_we = we; reg_sel = ws; reg_wdata = wd;
        cfg_we = cwe; cfg_range = cr; cfg_wrap_x = cx_en; cfg_wrap_y = cy_en;
        it.cx = chkx; it.xv = xe; it.cy = chky; it.yv = ye; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(input logic [2:0] ws, input logic [31:0] wd);
        step(0, 2'b00, 0, 2'b00, 1, ws, wd, 0, '0, 0, 0, 0, '0, 0, '0, "wr");
    endtask

    task automatic cfg(input logic [31:0] cr, input bit wx, input bit wy);
        step(0, 2'b00, 0, 2'b00, 0, '0, '0, 1, cr, wx, wy, 0, '0, 0, '0, "cfg");
    endtask

    task automatic mv(input bit xs, input logic [1:0] xm, input bit ys, input logic [1:0] ym);
        step(xs, xm, ys, ym, 0, '0, '0, 0, '0, 0, 0, 0, '0, 0, '0, "mv");
    endtask

    task automatic obs(input bit xs, input logic [31:0] xe, input bit ys, input logic [31:0] ye,
                       input string tag);
        step(xs, 2'b00, ys, 2'b00, 0, '0, '0, 0, '0, 0, 0, 1, xe, 1, ye, tag);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10: reset state of all pointers
        obs(0, 32'h0, 0, 32'h0, "R10 reset ptr0");
        obs(1, 32'h0, 1, 32'h0, "R10 reset ptr1");
        // R10: enables and values cleared -> +2 from zero gives 2; index reg cleared
        mv(0, 2'b01, 1, 2'b10);
        obs(0, 32'h2, 1, 32'h0, "R10 step after reset");

        wr(3'd0, 32'h1234_0100);
        wr(3'd1, 32'h0000_FFFE);
        wr(3'd2, 32'h0000_2000);
        wr(3'd3, 32'h5555_0108);
        wr(3'd4, 32'h0000_0006);
        wr(3'd5, 32'h0000_0010);
        // R2: pre-update value shown during the move
        step(0, 2'b01, 0, 2'b10, 0, '0, '0, 0, '0, 0, 0, 1, 32'h1234_0100, 1, 32'h0000_2000, "R2 pre-update addr");
        // R8: both buses advance in the same cycle, each with its own index
        obs(0, 32'h1234_0102, 0, 32'h0000_2010, "R8 parallel update");
        // R3: carry into upper half
        mv(1, 2'b01, 1, 2'b10);
        obs(1, 32'h0001_0000, 1, 32'h5555_0118, "R3 carry and index");

        // R1: config write same cycle as a move uses old config
        wr(3'd0, 32'h1234_0108);
        wr(3'd3, 32'h5555_0108);
        step(0, 2'b01, 0, 2'b00, 0, '0, '0, 1, 32'h0108_0100, 1, 0, 0, '0, 0, '0, "cfg+mv");
        obs(0, 32'h1234_010A, 1, 32'h5555_0108, "R1 old config same cycle");
        // R4 wrap on X, R7 no wrap on Y (disabled)
        wr(3'd0, 32'h1234_0108);
        mv(0, 2'b01, 1, 2'b01);
        obs(0, 32'h1234_0100, 1, 32'h5555_010A, "R4 R7 wrap X linear Y");

        // R6: hold modes at the match value
        wr(3'd0, 32'h1234_0108);
        mv(0, 2'b00, 0, 2'b00);
        obs(0, 32'h1234_0108, 0, 32'h0000_2010, "R6 hold 00");
        mv(0, 2'b11, 0, 2'b11);
        obs(0, 32'h1234_0108, 0, 32'h0000_2010, "R6 hold 11");

        // R5: bit 0 of pointer ignored
        wr(3'd0, 32'h1234_0109);
        mv(0, 2'b01, 0, 2'b00);
        obs(0, 32'h1234_0100, 0, 32'h0000_2010, "R5 odd pointer");
        // R5: bit 0 of wrap-at ignored
        cfg(32'h0109_0100, 1, 0);
        wr(3'd1, 32'hABCD_0108);
        mv(1, 2'b01, 0, 2'b00);
        obs(1, 32'hABCD_0100, 1, 32'h5555_010A, "R5 odd wrap-at");

        // R11: index mode wraps too; non-match index adds
        wr(3'd1, 32'hABCD_0108);
        mv(1, 2'b10, 0, 2'b00);
        obs(1, 32'hABCD_0100, 1, 32'h5555_010A, "R11 index wrap");
        mv(1, 2'b10, 0, 2'b00);
        obs(1, 32'hABCD_0106, 1, 32'h5555_010A, "R11 index linear");

        // R8: both buses wrap in the same cycle
        cfg(32'h0200_0040, 1, 1);
        wr(3'd0, 32'h0000_0200);
        wr(3'd2, 32'h7777_0200);
        mv(0, 2'b01, 0, 2'b10);
        obs(0, 32'h0000_0040, 0, 32'h7777_0040, "R8 dual wrap");

        // R9: write beats update of same register, other bus still moves
        step(0, 2'b01, 1, 2'b01, 1, 3'd0, 32'hDEAD_0000, 0, '0, 0, 0, 0, '0, 0, '0, "wr+mv");
        obs(0, 32'hDEAD_0000, 1, 32'h5555_010C, "R9 write priority");
        // R9: index write in same cycle as add-index uses old index
        step(0, 2'b00, 0, 2'b10, 1, 3'd5, 32'h0000_0020, 0, '0, 0, 0, 0, '0, 0, '0, "wr idx+mv");
        obs(0, 32'hDEAD_0000, 0, 32'h7777_0050, "R9 old index used");
        mv(0, 2'b00, 0, 2'b10);
        obs(0, 32'hDEAD_0000, 0, 32'h7777_0070, "R9 new index used");
        // R9: codes 6 and 7 write nothing
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        obs(0, 32'hDEAD_0000, 0, 32'h7777_0070, "R9 unused code ptr0");
        obs(1, 32'hABCD_0106, 1, 32'h5555_010C, "R9 unused code ptr1");
        mv(0, 2'b10, 0, 2'b10);
        obs(0, 32'hDEAD_0006, 0, 32'h7777_0090, "R9 unused code index");

        @(posedge clk);
        wait (q.size() == 0);
        @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule